// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the colour subcarrier phase word for an analog television encoder. It keeps three cascaded accumulators. A coarse 12-bit phase accumulator advances by a programmable step on every pixel. Two fractional accumulators work modulo a programmable size, and each one corrects the stage above it. When the middle accumulator rolls over, the coarse phase takes one extra count on that pixel. When the finest accumulator rolls over, the middle one takes one extra count. Together they give a subcarrier frequency that is a rational fraction of the pixel rate, with no long-term drift. The phase word drives a sine lookup placed after this block.

A field-start strobe advances a 3-bit field counter. A 2-bit policy code selects whether, and how often, that strobe returns every accumulator to zero. The available cadences are every 2, 4 or 8 fields, or never. This restores the same subcarrier phase at a known point in the field sequence.

Top module: `scdda_chain`

## Requirements
- R1: While reset is low, `phaseOut` is 0 and the internal field counter is 0. After reset, the first field-start strobe never clears the accumulators.
- R2: On a cycle with `pixEn` high, `coarseEn` high and no clear, the coarse phase becomes (phase + `coarseInc` + carry from the middle stage) mod 4096. The new value appears on `phaseOut` after that clock edge.
- R3: On each pixel with `midEn` high, the middle accumulator becomes acc + `midInc` + carry from the fine stage. If that sum is at least `midSize`, `midSize` is subtracted and a carry of 1 goes to the coarse phase on the same pixel. Operation assumes 0 < `midInc` < `midSize`.
- R4: On each pixel with `fineEn` high, the fine accumulator becomes acc + `fineInc`. If that sum is at least `fineSize`, `fineSize` is subtracted and a carry of 1 goes to the middle accumulator on the same pixel. Operation assumes 0 < `fineInc` < `fineSize`.
- R5: A stage whose enable is low holds its value and sends no carry. When `pixEn` is low, no accumulator moves.
- R6: Each `fieldStart` advances the field counter by one, modulo 8. A clear happens when the new count is a multiple of the period chosen by `resetPolicy`: code 0 gives a period of 2, code 1 gives 4, code 2 gives 8. Code 3 never clears.
- R7: A clear takes priority over a pixel step in the same cycle, so the pixel is not accumulated.
- R8: A clear sets all three accumulators to 0, so `phaseOut` reads 0 on the next cycle and the later fractional carries restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel clock enable |
| coarseEn | input | 1 | Enable of the coarse phase stage |
| midEn | input | 1 | Enable of the middle fractional stage |
| fineEn | input | 1 | Enable of the finest fractional stage |
| coarseInc | input | 12 | Coarse phase step per pixel |
| midInc | input | 15 | Middle stage step |
| midSize | input | 15 | Middle stage rollover size |
| fineInc | input | 15 | Finest stage step |
| fineSize | input | 15 | Finest stage rollover size |
| resetPolicy | input | 2 | Field cadence of phase clearing (0:2, 1:4, 2:8, 3:never) |
| fieldStart | input | 1 | Strobe marking the start of a field |
| phaseOut | output | 12 | Current subcarrier phase |

## Verification
The assertions check several properties on every cycle. Without a pixel, or with the coarse stage disabled, the phase stays fixed. With only the coarse stage running, the phase advances by exactly the step. A clear comes only from a field strobe, never happens under policy 3, excludes a pixel step, and is followed by a zero phase. The carry cascade, the modulo wrap of the fractional stages and the field cadence of each policy need a long history to judge. Only the bench scenarios cover them, by comparing `phaseOut` on every clock with a rational reference model across many fields.

// File: rtl/scdda_pkg.sv
package scdda_pkg;
  localparam int PHASE_W = 12;
  localparam int FRAC_W  = 15;
  localparam int FIELD_W = 3;

  typedef struct packed {
    logic step;   // accumulate this pixel
    logic clear;  // return all accumulators to zero
  } ddaCtl_t;

  typedef enum logic [1:0] {
    POL_EVERY2 = 2'd0,
    POL_EVERY4 = 2'd1,
    POL_EVERY8 = 2'd2,
    POL_NEVER  = 2'd3
  } resetPol_e;
endpackage

// File: rtl/scdda_ctl.sv
module scdda_ctl
  import scdda_pkg::*;
#(
  parameter int FIELD_BITS = FIELD_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixEn,
  input  logic       fieldStart,
  input  logic [1:0] resetPolicy,
  output ddaCtl_t    ctlBus
);
  logic [FIELD_BITS-1:0] fieldCnt;
  logic [FIELD_BITS-1:0] nextCnt;
  logic                  cadenceHit;

  assign nextCnt = fieldCnt + 1'b1;

  // the new count is a multiple of the selected period
  always_comb begin
    unique case (resetPol_e'(resetPolicy))
      POL_EVERY2: cadenceHit = (nextCnt[0] == 1'b0);
      POL_EVERY4: cadenceHit = (nextCnt[1:0] == 2'd0);
      POL_EVERY8: cadenceHit = (nextCnt[2:0] == 3'd0);
      default:    cadenceHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           fieldCnt <= '0;
    else if (fieldStart) fieldCnt <= nextCnt;
  end

  assign ctlBus.clear = fieldStart & cadenceHit;
  assign ctlBus.step  = pixEn & ~ctlBus.clear;
endmodule

// File: rtl/scdda_mod_stage.sv
module scdda_mod_stage #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         step,
  input  logic         en,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] size,
  input  logic         carryIn,
  output logic [W-1:0] acc,
  output logic         carryOut
);
  logic [W:0] sum;
  logic [W:0] wrapped;
  logic       overSize;

  assign sum      = {1'b0, acc} + {1'b0, inc} + {{W{1'b0}}, carryIn};
  assign overSize = (sum >= {1'b0, size});
  assign wrapped  = sum - {1'b0, size};
  assign carryOut = step & en & overSize;

  always_ff @(posedge clk) begin
    if (!rstN || clear)  acc <= '0;
    else if (step && en) acc <= overSize ? wrapped[W-1:0] : sum[W-1:0];
  end
endmodule

// File: rtl/scdda_datapath.sv
module scdda_datapath
  import scdda_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ddaCtl_t       ctlBus,
  input  logic          coarseEn,
  input  logic          midEn,
  input  logic          fineEn,
  input  logic [PW-1:0] coarseInc,
  input  logic [FW-1:0] midInc,
  input  logic [FW-1:0] midSize,
  input  logic [FW-1:0] fineInc,
  input  logic [FW-1:0] fineSize,
  output logic [PW-1:0] phaseOut
);
  localparam int NFRAC = 2;  // index 0 = finest, 1 = middle

  logic [NFRAC-1:0]         stgEn;
  logic [NFRAC-1:0][FW-1:0] stgInc;
  logic [NFRAC-1:0][FW-1:0] stgSize;
  logic [NFRAC-1:0][FW-1:0] stgAcc;
  logic [NFRAC:0]           carry;   // carry[0] feeds the finest stage

  assign stgEn   = {midEn, fineEn};
  assign stgInc  = {midInc, fineInc};
  assign stgSize = {midSize, fineSize};
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < NFRAC; g++) begin : g_frac
    scdda_mod_stage #(.W(FW)) u_stage (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (ctlBus.clear),
      .step     (ctlBus.step),
      .en       (stgEn[g]),
      .inc      (stgInc[g]),
      .size     (stgSize[g]),
      .carryIn  (carry[g]),
      .acc      (stgAcc[g]),
      .carryOut (carry[g+1])
    );
  end

  logic [PW-1:0] coarseAcc;
  always_ff @(posedge clk) begin
    if (!rstN || ctlBus.clear)
      coarseAcc <= '0;
    else if (ctlBus.step && coarseEn)
      coarseAcc <= coarseAcc + coarseInc + {{(PW-1){1'b0}}, carry[NFRAC]};
  end

  assign phaseOut = coarseAcc;
endmodule

// File: rtl/scdda_chain.sv
module scdda_chain
  import scdda_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pixEn,
  input  logic                 coarseEn,
  input  logic                 midEn,
  input  logic                 fineEn,
  input  logic [PHASE_W-1:0]   coarseInc,
  input  logic [FRAC_W-1:0]    midInc,
  input  logic [FRAC_W-1:0]    midSize,
  input  logic [FRAC_W-1:0]    fineInc,
  input  logic [FRAC_W-1:0]    fineSize,
  input  logic [1:0]           resetPolicy,
  input  logic                 fieldStart,
  output logic [PHASE_W-1:0]   phaseOut
);
  ddaCtl_t ctlBus;

  scdda_ctl #(.FIELD_BITS(FIELD_W)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .pixEn       (pixEn),
    .fieldStart  (fieldStart),
    .resetPolicy (resetPolicy),
    .ctlBus      (ctlBus)
  );

  scdda_datapath #(.PW(PHASE_W), .FW(FRAC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctlBus    (ctlBus),
    .coarseEn  (coarseEn),
    .midEn     (midEn),
    .fineEn    (fineEn),
    .coarseInc (coarseInc),
    .midInc    (midInc),
    .midSize   (midSize),
    .fineInc   (fineInc),
    .fineSize  (fineSize),
    .phaseOut  (phaseOut)
  );
endmodule

// File: rtl/scdda_chain_chk.sv
module scdda_chain_chk
  import scdda_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               pixEn,
  input logic               coarseEn,
  input logic               midEn,
  input logic               fieldStart,
  input logic [PHASE_W-1:0] coarseInc,
  input logic [1:0]         resetPolicy,
  input ddaCtl_t            ctlBus,
  input logic [PHASE_W-1:0] phaseOut
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!pixEn && !ctlBus.clear) |=> $stable(phaseOut)); // R5

  AST_COARSE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!coarseEn && !ctlBus.clear) |=> $stable(phaseOut)); // R5

  AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && coarseEn && !midEn && !ctlBus.clear)
      |=> phaseOut == PHASE_W'($past(phaseOut) + $past(coarseInc))); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctlBus.clear |=> phaseOut == '0); // R8

  AST_NEVER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (resetPolicy == 2'd3) |-> !ctlBus.clear); // R6

  AST_CLEAR_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ctlBus.clear |-> fieldStart); // R6

  AST_CLEAR_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    ctlBus.clear |-> !ctlBus.step); // R7
endmodule

bind scdda_chain scdda_chain_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pixEn       (pixEn),
  .coarseEn    (coarseEn),
  .midEn       (midEn),
  .fieldStart  (fieldStart),
  .coarseInc   (coarseInc),
  .resetPolicy (resetPolicy),
  .ctlBus      (ctlBus),
  .phaseOut    (phaseOut)
);

// File: tb/scdda_chain_tb.sv
module scdda_chain_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rstN = 1'b0;
  logic        pixEn = 1'b0, coarseEn = 1'b0, midEn = 1'b0, fineEn = 1'b0;
  logic [11:0] coarseInc = '0;
  logic [14:0] midInc = '0, midSize = 15'd1, fineInc = '0, fineSize = 15'd1;
  logic [1:0]  resetPolicy = 2'd3;
  logic        fieldStart = 1'b0;
  logic [11:0] phaseOut;

  scdda_chain u_dut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .coarseEn(coarseEn),
    .midEn(midEn), .fineEn(fineEn), .coarseInc(coarseInc),
    .midInc(midInc), .midSize(midSize), .fineInc(fineInc),
    .fineSize(fineSize), .resetPolicy(resetPolicy),
    .fieldStart(fieldStart), .phaseOut(phaseOut)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  string curReq = "R1";
  // reference model state
  int mPh = 0, mMid = 0, mFine = 0, mFld = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: phase actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // rational reference: applied at the edge with the inputs held since the last negedge
  task automatic modelEdge();
    int cF, cM, period;
    bit clr;
    if (!rstN) begin
      mPh = 0; mMid = 0; mFine = 0; mFld = 0;
      return;
    end
    clr = 0;
    if (fieldStart) begin
      mFld = (mFld + 1) % 8;
      period = (resetPolicy == 0) ? 2 : (resetPolicy == 1) ? 4 : 8;
      if (resetPolicy != 3 && (mFld % period) == 0) clr = 1;
    end
    if (clr) begin
      mPh = 0; mMid = 0; mFine = 0;
    end else if (pixEn) begin
      cF = 0; cM = 0;
      if (fineEn) begin
        mFine = mFine + int'(fineInc);
        if (mFine >= int'(fineSize)) begin mFine -= int'(fineSize); cF = 1; end
      end
      if (midEn) begin
        mMid = mMid + int'(midInc) + cF;
        if (mMid >= int'(midSize)) begin mMid -= int'(midSize); cM = 1; end
      end
      if (coarseEn) mPh = (mPh + int'(coarseInc) + cM) % 4096;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(curReq, int'(phaseOut), mPh);
  endtask

  // n cycles with a pixel pattern that skips every third cycle when gappy
  task automatic runPix(int n, bit gappy);
    for (int k = 0; k < n; k++) begin
      pixEn = gappy ? (k % 3 != 2) : 1'b1;
      tick();
    end
    pixEn = 1'b0;
  endtask

  task automatic runFields(int nFields, int linePix);
    for (int f = 0; f < nFields; f++) begin
      fieldStart = 1'b1;
      pixEn = 1'b0;
      tick();
      fieldStart = 1'b0;
      runPix(linePix, 1'b1);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", int'(phaseOut), 0);
    rstN = 1'b1;
    curReq = "R1";
    tick();

    // R2: coarse stage alone, including a wrap past 4095
    curReq = "R2";
    coarseEn = 1'b1; coarseInc = 12'd700;
    runPix(30, 1'b0);
    coarseInc = 12'd4095;
    runPix(10, 1'b1);

    // R3: middle stage carries into the phase
    curReq = "R3";
    coarseInc = 12'd100; midEn = 1'b1; midInc = 15'd3; midSize = 15'd7;
    runPix(40, 1'b1);
    midInc = 15'd6;
    runPix(20, 1'b0);

    // R4: finest stage carries into the middle stage
    curReq = "R4";
    fineEn = 1'b1; fineInc = 15'd5; fineSize = 15'd11;
    midInc = 15'd2; midSize = 15'd5;
    runPix(60, 1'b1);
    fineInc = 15'd10; midInc = 15'd4;  // carry-in with midInc = size-1
    runPix(40, 1'b0);

    // R5: disabled stages hold and send no carries; idle pixels
    curReq = "R5";
    midEn = 1'b0;
    runPix(20, 1'b0);
    midEn = 1'b1; fineEn = 1'b0;
    runPix(20, 1'b1);
    coarseEn = 1'b0; fineEn = 1'b1;
    runPix(20, 1'b0);
    coarseEn = 1'b1;
    for (int k = 0; k < 6; k++) tick();

    // R1 and R6: fresh counter, cadence of every policy code
    rstN = 1'b0;
    curReq = "R1";
    tick(); tick();
    rstN = 1'b1;
    curReq = "R6";
    resetPolicy = 2'd0;
    runFields(5, 9);
    resetPolicy = 2'd1;
    runFields(9, 7);
    resetPolicy = 2'd2;
    runFields(17, 5);
    resetPolicy = 2'd3;
    runFields(10, 6);

    // R7: strobe and pixel in the same cycle under a clearing cadence
    curReq = "R7";
    resetPolicy = 2'd0;
    for (int f = 0; f < 6; f++) begin
      fieldStart = 1'b1; pixEn = 1'b1;
      tick();
      fieldStart = 1'b0;
      runPix(13, 1'b0);
    end

    // R8: after a clear, the fractional stages restart from zero
    curReq = "R8";
    coarseInc = 12'd0; midInc = 15'd1; midSize = 15'd4;
    fineInc = 15'd1; fineSize = 15'd3;
    runFields(4, 25);

    summary();
  end
endmodule